// File: doc/BRIEF.md
# Dual-Mode Bus Register Interface

This block is a bus slave that gives a host processor access to a small file of 8-bit control and status locations. A strap input picks the bus style. With the strap high, one 8-bit port carries both the address and the data: the address is caught when the address-latch strobe falls, and the other port keeps driving that caught address so that neighbouring devices can use it. With the strap low, the first port carries only the address and the second port carries the data in both directions.

All bus inputs are sampled on the system clock, and a five-state machine runs each access. BUS_IDLE waits for a selected strobe. On a selected read strobe (IDLE→READ) it enters BUS_READ and drives data. On release or deselect (READ→READ_END) it enters BUS_READ_END for one cycle, which marks the location as read, then returns to idle (READ_END→IDLE). On a selected write strobe (IDLE→WRITE) it enters BUS_WRITE and holds the address and data. When the strobe rises (WRITE→COMMIT) it enters BUS_WRITE_COMMIT and stores the captured value. If the select drops first, the write is abandoned (WRITE→IDLE). COMMIT returns to idle (COMMIT→IDLE). When both strobes are low in idle, the read wins.

Four watched status locations raise an active-low interrupt when their inputs change. Each watched location keeps its own pending flag, and that flag is cleared by a completed read of that location.

Top module: `cpu_regif_top`

## Requirements
- R1: With `mux_mode_i` = 0, port A carries the address, port B carries the write data and returns the read data, and `bus_a_oe_o` never asserts.
- R2: With `mux_mode_i` = 1, the address on port A is latched when `ale_i` falls. Write data is then taken from port A, and read data is returned on port A.
- R3: With `mux_mode_i` = 1, `bus_b_oe_o` is high and `bus_b_o` shows the most recently latched address.
- R4: An access takes effect only when `cs_a_i` and `cs_b_i` are both high. A write with either select low leaves the target unchanged, and a read with either select low drives nothing.
- R5: A selected write stores its data when `wr_n_i` rises. Writable locations are 00h–0Bh, 0Fh, 1Eh and 1Fh, and they read back the stored value. `ctrl_regs_o` holds them in slots 0–14: slot i is at bits [8i+7:8i], slots 0–11 are 00h–0Bh, and slots 12–14 are 0Fh, 1Eh and 1Fh.
- R6: Read-only locations return the sampled status inputs, and writes to them are ignored. The mapping is 0Ch←`stat_tone_i`, 0Dh←`stat_link_i`, 0Eh←`stat_aux_i`, 1Ch←`stat_ext_i` and 1Dh←`stat_diag_i`.
- R7: Any address outside the twenty decoded locations reads 00h, and a write to it changes no location.
- R8: The read data enable rises two clock edges after a selected low read strobe is present, and it falls once the strobe is released. Outside a read it is low.
- R9: A change on the input of 0Ch, 0Dh, 1Ch or 1Dh drives `irq_n_o` low one clock later. A change on the input of 0Eh does not.
- R10: Each watched location has its own pending flag. A completed read of that location clears its flag, and `irq_n_o` returns high only when no flag is pending.
- R11: If a watched input changes in the same cycle as the clearing read of that location, its flag stays set.
- R12: After reset, `irq_n_o` is high, both enables are low in separate mode, and every writable location holds 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mux_mode_i | input | 1 | Strap: 1 = shared address/data, 0 = separate buses |
| cs_a_i | input | 1 | Chip select, active high |
| cs_b_i | input | 1 | Chip select, active high |
| ale_i | input | 1 | Address latch strobe; its falling edge is used |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low; data is taken on its rise |
| bus_a_i | input | 8 | Port A input value |
| bus_a_o | output | 8 | Port A driven value (read data, shared mode) |
| bus_a_oe_o | output | 1 | Port A drive enable |
| bus_b_i | input | 8 | Port B input value (write data, separate mode) |
| bus_b_o | output | 8 | Port B driven value (read data or latched address) |
| bus_b_oe_o | output | 1 | Port B drive enable |
| stat_tone_i | input | 8 | Status source for 0Ch (watched) |
| stat_link_i | input | 8 | Status source for 0Dh (watched) |
| stat_ext_i | input | 8 | Status source for 1Ch (watched) |
| stat_diag_i | input | 8 | Status source for 1Dh (watched) |
| stat_aux_i | input | 8 | Status source for 0Eh (not watched) |
| ctrl_regs_o | output | 120 | Writable locations, slot order as in R5 |
| irq_n_o | output | 1 | Status-change interrupt, active low |

## Verification
The bench builds the block with its default 8-bit bus. At that width the whole 256-entry address space is small enough to be swept. In each bus mode, every address is written with a value derived from the address, and every address is then read back. The expected result is computed from the address class, so every decoded, read-only and undecoded location is covered in both modes. Directed sequences add partial selects, an unwatched status change, overlapping pending flags, and a status change timed onto the exact cycle of a clearing read.

// File: rtl/regif_pkg.sv
package regif_pkg;

    localparam int BUS_W   = 8;
    localparam int N_STORE = 15;
    localparam int N_STAT  = 5;
    localparam int N_WATCH = 4;
    localparam int N_LOW   = 12;

    typedef enum logic [2:0] {
        BUS_IDLE,
        BUS_READ,
        BUS_READ_END,
        BUS_WRITE,
        BUS_WRITE_COMMIT
    } bus_state_e;

    // Address of writable slot idx (slot order is visible on ctrl_regs_o).
    function automatic logic [BUS_W-1:0] store_addr(input int idx);
        if (idx < N_LOW)
            return BUS_W'(idx);
        else if (idx == N_LOW)
            return BUS_W'(8'h0F);
        else if (idx == N_LOW + 1)
            return BUS_W'(8'h1E);
        else
            return BUS_W'(8'h1F);
    endfunction

    // Address of status slot idx; the first N_WATCH slots raise the interrupt.
    function automatic logic [BUS_W-1:0] stat_addr(input int idx);
        case (idx)
            0:       return BUS_W'(8'h0C);
            1:       return BUS_W'(8'h0D);
            2:       return BUS_W'(8'h1C);
            3:       return BUS_W'(8'h1D);
            default: return BUS_W'(8'h0E);
        endcase
    endfunction

endpackage

// File: rtl/regif_sample.sv
module regif_sample #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= RST_VAL;
        else
            q <= d;
    end

endmodule

// File: rtl/regif_bus_fsm.sv
module regif_bus_fsm
    import regif_pkg::*;
#(
    parameter int AW = BUS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mux_mode,
    input  logic          ale_s,
    input  logic          rd_n_s,
    input  logic          wr_n_s,
    input  logic          sel_s,
    input  logic [AW-1:0] a_s,
    input  logic [AW-1:0] b_s,
    output bus_state_e    state_o,
    output logic [AW-1:0] acc_addr_o,
    output logic [AW-1:0] latched_addr_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [AW-1:0] wr_data_o,
    output logic [AW-1:0] done_addr_o,
    output logic          rd_active_o,
    output logic          rd_done_o,
    output logic          wr_en_o
);

    bus_state_e    st_q;
    bus_state_e    st_d;
    logic          ale_prev_q;
    logic [AW-1:0] alat_q;
    logic [AW-1:0] wr_addr_q;
    logic [AW-1:0] wr_data_q;
    logic [AW-1:0] rd_addr_q;
    logic          ale_fall;
    logic [AW-1:0] acc_addr;

    assign ale_fall = ale_prev_q & ~ale_s;
    assign acc_addr = mux_mode ? alat_q : a_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ale_prev_q <= 1'b0;
            alat_q     <= '0;
        end else begin
            ale_prev_q <= ale_s;
            if (ale_fall)
                alat_q <= a_s;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= BUS_IDLE;
        else
            st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BUS_IDLE: begin
                if (sel_s && !rd_n_s)
                    st_d = BUS_READ;
                else if (sel_s && !wr_n_s)
                    st_d = BUS_WRITE;
            end
            BUS_READ: begin
                if (!sel_s || rd_n_s)
                    st_d = BUS_READ_END;
            end
            BUS_READ_END: st_d = BUS_IDLE;
            BUS_WRITE: begin
                if (!sel_s)
                    st_d = BUS_IDLE;
                else if (wr_n_s)
                    st_d = BUS_WRITE_COMMIT;
            end
            BUS_WRITE_COMMIT: st_d = BUS_IDLE;
            default: st_d = BUS_IDLE;
        endcase
    end

    // Access datapath: address and data follow the bus while the strobe is held
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_addr_q <= '0;
            wr_data_q <= '0;
            rd_addr_q <= '0;
        end else begin
            if (st_q == BUS_WRITE) begin
                wr_addr_q <= acc_addr;
                wr_data_q <= mux_mode ? a_s : b_s;
            end
            if (st_q == BUS_READ)
                rd_addr_q <= acc_addr;
        end
    end

    // Outputs
    always_comb begin
        rd_active_o = (st_q == BUS_READ);
        rd_done_o   = (st_q == BUS_READ_END);
        wr_en_o     = (st_q == BUS_WRITE_COMMIT);
    end

    assign state_o        = st_q;
    assign acc_addr_o     = acc_addr;
    assign latched_addr_o = alat_q;
    assign wr_addr_o      = wr_addr_q;
    assign wr_data_o      = wr_data_q;
    assign done_addr_o    = rd_addr_q;

endmodule

// File: rtl/regif_store.sv
module regif_store
    import regif_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [BUS_W-1:0]           wr_addr,
    input  logic [BUS_W-1:0]           wr_data,
    input  logic [BUS_W-1:0]           rd_addr,
    input  logic [N_STAT*BUS_W-1:0]    stat_flat,
    output logic [BUS_W-1:0]           rd_data,
    output logic [N_STORE*BUS_W-1:0]   store_flat
);

    for (genvar g = 0; g < N_STORE; g++) begin : g_slot
        logic [BUS_W-1:0] slot_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_q <= '0;
            else if (wr_en && (wr_addr == store_addr(g)))
                slot_q <= wr_data;
        end
        assign store_flat[g*BUS_W +: BUS_W] = slot_q;
    end

    // Read decode: undecoded addresses fall through to zero
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N_STORE; i++) begin
            if (rd_addr == store_addr(i))
                rd_data = store_flat[i*BUS_W +: BUS_W];
        end
        for (int j = 0; j < N_STAT; j++) begin
            if (rd_addr == stat_addr(j))
                rd_data = stat_flat[j*BUS_W +: BUS_W];
        end
    end

endmodule

// File: rtl/regif_irq.sv
module regif_irq
    import regif_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_STAT*BUS_W-1:0] stat_in,
    input  logic                    clr_en,
    input  logic [BUS_W-1:0]        clr_addr,
    output logic [N_STAT*BUS_W-1:0] stat_q,
    output logic                    irq_n
);

    logic [N_WATCH-1:0] pend;

    regif_sample #(.W(N_STAT*BUS_W)) u_snap (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (stat_in),
        .q     (stat_q)
    );

    for (genvar w = 0; w < N_WATCH; w++) begin : g_watch
        logic chg;
        logic clr;
        logic pend_q;
        assign chg = (stat_in[w*BUS_W +: BUS_W] != stat_q[w*BUS_W +: BUS_W]);
        assign clr = clr_en && (clr_addr == stat_addr(w));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                pend_q <= 1'b0;
            else
                pend_q <= chg | (pend_q & ~clr);
        end
        assign pend[w] = pend_q;
    end

    assign irq_n = ~|pend;

endmodule

// File: rtl/cpu_regif_top.sv
module cpu_regif_top
    import regif_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mux_mode_i,
    input  logic                     cs_a_i,
    input  logic                     cs_b_i,
    input  logic                     ale_i,
    input  logic                     rd_n_i,
    input  logic                     wr_n_i,
    input  logic [BUS_W-1:0]         bus_a_i,
    output logic [BUS_W-1:0]         bus_a_o,
    output logic                     bus_a_oe_o,
    input  logic [BUS_W-1:0]         bus_b_i,
    output logic [BUS_W-1:0]         bus_b_o,
    output logic                     bus_b_oe_o,
    input  logic [BUS_W-1:0]         stat_tone_i,
    input  logic [BUS_W-1:0]         stat_link_i,
    input  logic [BUS_W-1:0]         stat_ext_i,
    input  logic [BUS_W-1:0]         stat_diag_i,
    input  logic [BUS_W-1:0]         stat_aux_i,
    output logic [N_STORE*BUS_W-1:0] ctrl_regs_o,
    output logic                     irq_n_o
);

    localparam int CTL_W = 4;

    logic [CTL_W-1:0]        ctl_s;
    logic [2*BUS_W-1:0]      dat_s;
    logic [N_STAT*BUS_W-1:0] stat_raw;
    logic [N_STAT*BUS_W-1:0] stat_q;
    bus_state_e              bus_state;
    logic [BUS_W-1:0]        acc_addr;
    logic [BUS_W-1:0]        latched_addr;
    logic [BUS_W-1:0]        wr_addr;
    logic [BUS_W-1:0]        wr_data;
    logic [BUS_W-1:0]        done_addr;
    logic [BUS_W-1:0]        rd_data;
    logic                    rd_active;
    logic                    rd_done;
    logic                    wr_en;

    // Sampled order: {ale, rd_n, wr_n, select}
    regif_sample #(.W(CTL_W), .RST_VAL(4'b0110)) u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ale_i, rd_n_i, wr_n_i, cs_a_i & cs_b_i}),
        .q     (ctl_s)
    );

    regif_sample #(.W(2*BUS_W)) u_dat (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({bus_a_i, bus_b_i}),
        .q     (dat_s)
    );

    regif_bus_fsm #(.AW(BUS_W)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .mux_mode       (mux_mode_i),
        .ale_s          (ctl_s[3]),
        .rd_n_s         (ctl_s[2]),
        .wr_n_s         (ctl_s[1]),
        .sel_s          (ctl_s[0]),
        .a_s            (dat_s[2*BUS_W-1:BUS_W]),
        .b_s            (dat_s[BUS_W-1:0]),
        .state_o        (bus_state),
        .acc_addr_o     (acc_addr),
        .latched_addr_o (latched_addr),
        .wr_addr_o      (wr_addr),
        .wr_data_o      (wr_data),
        .done_addr_o    (done_addr),
        .rd_active_o    (rd_active),
        .rd_done_o      (rd_done),
        .wr_en_o        (wr_en)
    );

    assign stat_raw = {stat_aux_i, stat_diag_i, stat_ext_i, stat_link_i, stat_tone_i};

    regif_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .stat_in  (stat_raw),
        .clr_en   (rd_done),
        .clr_addr (done_addr),
        .stat_q   (stat_q),
        .irq_n    (irq_n_o)
    );

    regif_store u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (acc_addr),
        .stat_flat  (stat_q),
        .rd_data    (rd_data),
        .store_flat (ctrl_regs_o)
    );

    assign bus_a_o    = rd_data;
    assign bus_a_oe_o = mux_mode_i & rd_active;
    assign bus_b_o    = mux_mode_i ? latched_addr : rd_data;
    assign bus_b_oe_o = mux_mode_i | rd_active;

endmodule

// File: rtl/regif_checker.sv
module regif_checker
    import regif_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic                     mux_mode_i,
    input logic                     cs_a_i,
    input logic                     cs_b_i,
    input logic                     rd_n_i,
    input logic                     bus_a_oe_o,
    input logic                     bus_b_oe_o,
    input logic                     irq_n_o,
    input logic [N_STORE*BUS_W-1:0] ctrl_regs_o,
    input logic [N_WATCH*BUS_W-1:0] watch_vec,
    input bus_state_e               fsm_state
);

    logic rd_drive;
    assign rd_drive = bus_a_oe_o | (bus_b_oe_o & ~mux_mode_i);

    // R1
    port_a_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_a_oe_o |-> mux_mode_i);

    // R8
    rd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_drive |-> $past(!rd_n_i && cs_a_i && cs_b_i, 2));

    // R9
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (watch_vec != $past(watch_vec)) |=> !irq_n_o);

    // R10
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n_o && fsm_state != BUS_READ_END) |=> !irq_n_o);

    // R5
    store_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_regs_o) |-> $past(fsm_state == BUS_WRITE_COMMIT));

endmodule

bind cpu_regif_top regif_checker chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mux_mode_i  (mux_mode_i),
    .cs_a_i      (cs_a_i),
    .cs_b_i      (cs_b_i),
    .rd_n_i      (rd_n_i),
    .bus_a_oe_o  (bus_a_oe_o),
    .bus_b_oe_o  (bus_b_oe_o),
    .irq_n_o     (irq_n_o),
    .ctrl_regs_o (ctrl_regs_o),
    .watch_vec   ({stat_diag_i, stat_ext_i, stat_link_i, stat_tone_i}),
    .fsm_state   (bus_state)
);

// File: tb/cpu_regif_top_tb_top.sv
module cpu_regif_top_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mux_mode = 1'b0;
    logic         cs_a = 1'b0;
    logic         cs_b = 1'b0;
    logic         ale = 1'b0;
    logic         rd_n = 1'b1;
    logic         wr_n = 1'b1;
    logic [7:0]   bus_a = 8'h00;
    logic [7:0]   bus_b = 8'h00;
    logic [7:0]   tone = 8'h00;
    logic [7:0]   link = 8'h00;
    logic [7:0]   ext = 8'h00;
    logic [7:0]   diag = 8'h00;
    logic [7:0]   aux = 8'h00;
    logic [7:0]   bus_a_o;
    logic [7:0]   bus_b_o;
    logic         bus_a_oe;
    logic         bus_b_oe;
    logic [119:0] ctrl_regs;
    logic         irq_n;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;
    logic [7:0] mem [256];

    always #5 clk = ~clk;

    cpu_regif_top dut_i (
        .clk (clk), .rst_n (rst_n), .mux_mode_i (mux_mode),
        .cs_a_i (cs_a), .cs_b_i (cs_b), .ale_i (ale), .rd_n_i (rd_n), .wr_n_i (wr_n),
        .bus_a_i (bus_a), .bus_a_o (bus_a_o), .bus_a_oe_o (bus_a_oe),
        .bus_b_i (bus_b), .bus_b_o (bus_b_o), .bus_b_oe_o (bus_b_oe),
        .stat_tone_i (tone), .stat_link_i (link), .stat_ext_i (ext),
        .stat_diag_i (diag), .stat_aux_i (aux),
        .ctrl_regs_o (ctrl_regs), .irq_n_o (irq_n)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit is_store(input logic [7:0] a);
        return (a <= 8'h0B) || (a == 8'h0F) || (a == 8'h1E) || (a == 8'h1F);
    endfunction

    function automatic bit is_stat(input logic [7:0] a);
        return (a == 8'h0C) || (a == 8'h0D) || (a == 8'h0E) || (a == 8'h1C) || (a == 8'h1D);
    endfunction

    function logic [7:0] expect_rd(input logic [7:0] a);
        case (a)
            8'h0C: return tone;
            8'h0D: return link;
            8'h0E: return aux;
            8'h1C: return ext;
            8'h1D: return diag;
            default: return is_store(a) ? mem[a] : 8'h00;
        endcase
    endfunction

    task automatic addr_phase(input logic [7:0] a);
        @(negedge clk);
        if (mux_mode) begin
            ale = 1'b1; bus_a = a;
            @(negedge clk);
            ale = 1'b0;
            repeat (2) @(negedge clk);
        end else begin
            bus_a = a;
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d,
                             input logic csa, input logic csb);
        addr_phase(a);
        if (mux_mode) bus_a = d; else bus_b = d;
        cs_a = csa; cs_b = csb; wr_n = 1'b0;
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        repeat (3) @(negedge clk);
        cs_a = 1'b0; cs_b = 1'b0;
        if (csa && csb && is_store(a)) mem[a] = d;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic csa, input logic csb,
                            output logic [7:0] d, output logic oe,
                            output logic oe_after, output logic [7:0] lat);
        addr_phase(a);
        if (mux_mode) bus_a = 8'hEE;
        cs_a = csa; cs_b = csb; rd_n = 1'b0;
        repeat (3) @(negedge clk);
        d   = mux_mode ? bus_a_o : bus_b_o;
        oe  = mux_mode ? bus_a_oe : bus_b_oe;
        lat = bus_b_o;
        rd_n = 1'b1;
        repeat (3) @(negedge clk);
        oe_after = mux_mode ? bus_a_oe : bus_b_oe;
        cs_a = 1'b0; cs_b = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        logic       oe;
        logic       oe2;
        logic [7:0] lat;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R12 reset state
        check("R12 irq", irq_n, 1);
        check("R12 oe_a", bus_a_oe, 0);
        check("R12 oe_b", bus_b_oe, 0);
        check("R12 regs", (ctrl_regs == 120'd0), 1);

        // R1 separate-mode access
        bus_write(8'h03, 8'h6D, 1, 1);
        bus_read(8'h03, 1, 1, d, oe, oe2, lat);
        check("R1 data", d, 8'h6D);
        check("R1 oe_b", oe, 1);
        check("R1 oe_a", bus_a_oe, 0);

        // R4 partial select
        bus_write(8'h03, 8'h11, 1, 0);
        bus_write(8'h03, 8'h22, 0, 1);
        bus_read(8'h03, 0, 1, d, oe, oe2, lat);
        check("R4 no drive", oe, 0);
        bus_read(8'h03, 1, 1, d, oe, oe2, lat);
        check("R4 write ignored", d, 8'h6D);

        // R9 set statuses: watched changes raise irq
        @(negedge clk);
        tone = 8'h81; link = 8'h42; ext = 8'h24; diag = 8'h18;
        repeat (2) @(negedge clk);
        check("R9 irq low", irq_n, 0);

        // R2 shared-mode access
        mux_mode = 1'b1;
        bus_write(8'h1E, 8'hC3, 1, 1);
        bus_read(8'h1E, 1, 1, d, oe, oe2, lat);
        check("R2 data", d, 8'hC3);
        check("R2 oe_a", oe, 1);
        check("R3 latched", lat, 8'h1E);
        check("R3 oe_b", bus_b_oe, 1);

        // Full sweeps in both modes
        for (int m = 0; m < 2; m++) begin
            mux_mode = m[0];
            for (int a = 0; a < 256; a++)
                bus_write(a[7:0], a[7:0] ^ (m[0] ? 8'hA5 : 8'h3C), 1, 1);
            for (int a = 0; a < 256; a++) begin
                bus_read(a[7:0], 1, 1, d, oe, oe2, lat);
                if (is_store(a[7:0]))     check("R5 readback", d, expect_rd(a[7:0]));
                else if (is_stat(a[7:0])) check("R6 status", d, expect_rd(a[7:0]));
                else                      check("R7 undecoded", d, 8'h00);
                check("R8 oe during", oe, 1);
                check("R8 oe after", oe2, 0);
                if (m == 1) check("R3 latched", lat, a[7:0]);
            end
        end

        // R5 slot layout
        for (int s = 0; s < 15; s++) begin
            logic [7:0] sa;
            sa = (s < 12) ? s[7:0] : ((s == 12) ? 8'h0F : ((s == 13) ? 8'h1E : 8'h1F));
            check("R5 slot", ctrl_regs[s*8 +: 8], sa ^ 8'hA5);
        end

        // R10 all watched read during sweep
        check("R10 irq released", irq_n, 1);

        mux_mode = 1'b0;
        // R9 unwatched change
        @(negedge clk);
        aux = 8'h5E;
        repeat (3) @(negedge clk);
        check("R9 aux no irq", irq_n, 1);

        // R10 per-location flags
        @(negedge clk);
        tone = 8'h07; diag = 8'hF0;
        repeat (2) @(negedge clk);
        check("R9 irq low again", irq_n, 0);
        bus_read(8'h0C, 1, 1, d, oe, oe2, lat);
        check("R6 tone value", d, 8'h07);
        check("R10 still pending", irq_n, 0);
        bus_read(8'h1D, 1, 1, d, oe, oe2, lat);
        check("R10 cleared", irq_n, 1);

        // R11 change on the clearing cycle
        @(negedge clk);
        link = 8'h99;
        repeat (2) @(negedge clk);
        bus_a = 8'h0D; cs_a = 1'b1; cs_b = 1'b1; rd_n = 1'b0;
        repeat (3) @(negedge clk);
        rd_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        link = 8'h3A;
        @(negedge clk);
        @(negedge clk);
        cs_a = 1'b0; cs_b = 1'b0;
        check("R11 kept", irq_n, 0);
        bus_read(8'h0D, 1, 1, d, oe, oe2, lat);
        check("R11 value", d, 8'h3A);
        check("R11 cleared after", irq_n, 1);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule